// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with 19 address bits, an 8-bit shared data bus and active-low select, output-enable and write-enable strobes. The host hands over one word at a time through a request/ready handshake. The controller then runs the strobe sequence the RAM needs. Every minimum time in that sequence is met by holding a phase for a whole number of system clocks.

Each phase length is the ceiling of a nanosecond limit divided by the clock period, with a floor of one cycle. The limits come from a speed-grade parameter (55 or 70) and the period comes from a clock parameter. The shared data bus is exposed as three signals: a driven value, a drive enable and a sampled input. The pad tristate is built outside this block. On a read, the captured byte returns to the host with a one-cycle valid pulse.

The default setting is grade 55 at an 8 ns clock, which gives these phase lengths:

- A read holds the strobes low for 7 cycles.
- The bus turn-around phase is 3 cycles.
- The write pulse is 7 cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every idle cycle between accesses, select, output enable and write enable are all high, the data bus is not driven, `req_ready` is high and `rsp_valid` is low.
- R2: A read lowers select and output enable with write enable high for RD_CYC cycles. RD_CYC is the largest of the ceilings of read cycle time, address access time and output-enable access time (7 at the default). The bus is sampled at the clock edge that ends this phase, and `rsp_valid` is high for exactly one cycle with that byte on `rsp_rdata`.
- R3: A write runs three phases in order. First, select is low with output enable and write enable high for HZ_CYC cycles (3 at the default). Second, write enable is low for WP_CYC cycles (7 at the default). Third, one cycle follows with write enable back high and select still low. Write enable is never low while select is high.
- R4: The address is captured when the request is accepted. It stays constant on `ram_addr` for every cycle that select is low, even if the host request inputs change.
- R5: Write data is driven and constant on every cycle write enable is low. It is also driven for the one cycle after write enable rises, and the drive is released together with the rise of select.
- R6: The controller never drives the data bus while output enable is low, and output enable is never low while write enable is low.
- R7: The controller starts driving the bus no earlier than HZ_CYC full cycles after output enable was last high-going.
- R8: `req_ready` is low from the cycle after acceptance until the access has finished. A request presented while `req_ready` is low has no effect.
- R9: Phase lengths are ceil(t / period), with a minimum of 1. WP_CYC is the largest of these: write pulse width, data setup, select-to-end and address-to-end, and the write cycle time minus HZ_CYC minus 1.
- R10: Consecutive accesses, whether write then read or read then write, are separated by at least one idle cycle with all strobes high. A read that follows a write returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 19 | RAM address lines |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | 8 | Value to drive onto the data bus |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bound checker watches several properties on every cycle:

- the bus-ownership rules: no drive while output enable is low, and output enable stays high while writing;
- address and data stability across each select-low window;
- write enable staying inside select;
- the write-pulse width and the turn-around wait, using counters;
- the busy indication and the single-cycle response pulse.

Other behaviour only the directed scenarios can show, using a behavioural RAM model in the bench:

- the exact phase lengths for the default grade;
- that a byte written is the byte read back;
- that a request arriving mid-access leaves memory untouched;
- the idle gap between write-then-read and read-then-write pairs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD       = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_END   = 3'd4
    } ctrl_state_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic int ceil_cycles(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bus turn-off time after output enable / select / write enable change
    function automatic int hz_cycles(input int grade, input int clk_ps);
        return ceil_cycles((grade == 70) ? 25000 : 20000, clk_ps);
    endfunction

    // Read: cycle time, address/select access and output-enable access
    function automatic int rd_cycles(input int grade, input int clk_ps);
        int t_cyc;
        int t_oe;
        t_cyc = (grade == 70) ? 70000 : 55000;
        t_oe  = (grade == 70) ? 35000 : 25000;
        return imax(ceil_cycles(t_cyc, clk_ps), ceil_cycles(t_oe, clk_ps));
    endfunction

    // Write pulse: width, data setup, select-to-end, address-to-end, cycle fill
    function automatic int wp_cycles(input int grade, input int clk_ps);
        int w_pulse;
        int w_data;
        int w_sel;
        int w_fill;
        w_pulse = ceil_cycles((grade == 70) ? 50000 : 40000, clk_ps);
        w_data  = ceil_cycles((grade == 70) ? 30000 : 25000, clk_ps);
        w_sel   = ceil_cycles((grade == 70) ? 60000 : 50000, clk_ps);
        w_fill  = ceil_cycles((grade == 70) ? 70000 : 55000, clk_ps)
                  - hz_cycles(grade, clk_ps) - 1;
        return imax(imax(w_pulse, w_data), imax(w_sel, w_fill));
    endfunction

    function automatic strobe_t strobes_for(input ctrl_state_t s);
        strobe_t o;
        o = STROBE_IDLE;
        case (s)
            ST_RD:       begin o.cs_n = 1'b0; o.oe_n = 1'b0; end
            ST_WR_TURN:  begin o.cs_n = 1'b0; end
            ST_WR_PULSE: begin o.cs_n = 1'b0; o.we_n = 1'b0; o.drive = 1'b1; end
            ST_WR_END:   begin o.cs_n = 1'b0; o.drive = 1'b1; end
            default:     o = STROBE_IDLE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 7,
    parameter int HZ_CYC = 3,
    parameter int WP_CYC = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             idle,
    output ctrl_state_t      state_next
);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

    ctrl_state_t state_q;

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle && req_valid;

    always_comb begin
        state_next = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        capture    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load   = 1'b1;
                    state_next = req_write ? ST_WR_TURN : ST_RD;
                    tmr_val    = req_write ? HZ_LOAD : RD_LOAD;
                end
            end
            ST_RD: begin
                if (expired) begin
                    capture    = 1'b1;
                    state_next = ST_IDLE;
                end
            end
            ST_WR_TURN: begin
                if (expired) begin
                    tmr_load   = 1'b1;
                    tmr_val    = WP_LOAD;
                    state_next = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    state_next = ST_WR_END;
                end
            end
            ST_WR_END: begin
                state_next = ST_IDLE;
            end
            default: state_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_next;
        end
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  ctrl_state_t       state_next,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output strobe_t           strobe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe     <= STROBE_IDLE;
            ram_addr   <= '0;
            ram_dq_out <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            strobe    <= strobes_for(state_next);
            rsp_valid <= capture;
            if (accept) begin
                ram_addr   <= req_addr;
                ram_dq_out <= req_wdata;
            end
            if (capture) begin
                rsp_rdata <= ram_dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int GRADE  = 55,
    parameter int CLK_PS = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    localparam int RD_CYC = rd_cycles(GRADE, CLK_PS);
    localparam int HZ_CYC = hz_cycles(GRADE, CLK_PS);
    localparam int WP_CYC = wp_cycles(GRADE, CLK_PS);
    localparam int CNT_W  = $clog2(imax(RD_CYC, imax(HZ_CYC, WP_CYC)) + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             expired;
    logic             accept;
    logic             capture;
    logic             idle;
    ctrl_state_t      state_next;
    strobe_t          strobe;

    sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sram_ctrl_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .HZ_CYC (HZ_CYC),
        .WP_CYC (WP_CYC)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .expired    (expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture),
        .idle       (idle),
        .state_next (state_next)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .state_next (state_next),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ram_dq_in  (ram_dq_in),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .strobe     (strobe),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign req_ready = idle;
    assign ram_cs_n  = strobe.cs_n;
    assign ram_oe_n  = strobe.oe_n;
    assign ram_we_n  = strobe.we_n;
    assign ram_dq_oe = strobe.drive;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int HZ_CYC = 3,
    parameter int WP_CYC = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ram_cs_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              ram_dq_oe,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_dq_out
);
    logic [15:0] we_low_cnt;
    logic [15:0] oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= '0;
        end else begin
            we_low_cnt  <= ram_we_n ? 16'd0 : we_low_cnt + 16'd1;
            if (!ram_oe_n) begin
                oe_high_cnt <= '0;
            end else if (oe_high_cnt != 16'hFFFF) begin
                oe_high_cnt <= oe_high_cnt + 16'd1;
            end
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe && req_ready)); // R1
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_cs_n); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (int'(we_low_cnt) >= WP_CYC)); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr)); // R4
    AST_DATA_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> ram_dq_oe); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out)); // R5
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (ram_dq_oe && !ram_cs_n)); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n); // R6
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> ram_oe_n); // R6
    AST_TURNOFF_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_dq_oe) |-> (int'(oe_high_cnt) >= HZ_CYC)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_n |-> !req_ready); // R8
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HZ_CYC (HZ_CYC),
    .WP_CYC (WP_CYC)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .ram_cs_n   (ram_cs_n),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n),
    .ram_dq_oe  (ram_dq_oe),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
    localparam int CLK_PS = 8000;
    // Expected phase lengths for grade 55, computed from the ns limits (R9)
    localparam int E_HZ = (20000 + CLK_PS - 1) / CLK_PS;                   // 3
    localparam int E_RD = (55000 + CLK_PS - 1) / CLK_PS;                   // 7
    localparam int E_WP = (50000 + CLK_PS - 1) / CLK_PS;                   // 7

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] ram_addr;
    logic        ram_cs_n, ram_oe_n, ram_we_n;
    logic [7:0]  ram_dq_out;
    logic        ram_dq_oe;
    logic [7:0]  ram_dq_in;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // Behavioural RAM: write lands when write enable rises with select low
    logic [7:0] mem [logic [18:0]];
    always @(posedge ram_we_n) begin
        if (ram_cs_n === 1'b0) mem[ram_addr] = ram_dq_out;
    end
    always @* begin
        if (ram_cs_n === 1'b0 && ram_oe_n === 1'b0 && ram_we_n === 1'b1)
            ram_dq_in = mem.exists(ram_addr) ? mem[ram_addr] : 8'hEE;
        else
            ram_dq_in = 8'h00;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic check_idle(input string tag);
        check(ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid,
              tag, "idle strobes", {ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe, req_ready, rsp_valid},
              6'b111010);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit poke);
        int turn = 0, pulse = 0, tail = 0, rdy = 0, g = 0;
        bit addr_bad = 0, data_bad = 0, contend = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_wdata = ~d;
        while (!ram_cs_n && g < 64) begin
            if (ram_addr !== a) addr_bad = 1;
            if (req_ready) rdy++;
            if (!ram_we_n) begin
                pulse++;
                if (!ram_dq_oe || ram_dq_out !== d || !ram_oe_n) data_bad = 1;
            end else if (pulse == 0) begin
                turn++;
                if (ram_dq_oe) contend = 1;
            end else begin
                tail++;
                if (!ram_dq_oe || ram_dq_out !== d) data_bad = 1;
            end
            if (poke && g == 2) begin
                req_valid = 1; req_write = 1; req_addr = a ^ 19'h1; req_wdata = 8'h5A;
            end else if (poke && g == 3) begin
                req_valid = 0;
            end
            @(negedge clk);
            g++;
        end
        check(turn == E_HZ, "R3", "turn-around cycles", turn, E_HZ);
        check(!contend, "R7", "bus driven during turn-around", contend, 0);
        check(pulse == E_WP, "R9", "write pulse cycles", pulse, E_WP);
        check(tail == 1, "R5", "hold cycles after write enable", tail, 1);
        check(!addr_bad, "R4", "address stable", addr_bad, 0);
        check(!data_bad, "R5", "write data driven", data_bad, 0);
        check(rdy == 0, "R8", "ready while busy", rdy, 0);
        check_idle("R10");
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
        int act = 0, g = 0;
        bit bad = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0; req_addr = ~a;
        while (!ram_cs_n && g < 64) begin
            if (ram_oe_n || !ram_we_n || ram_dq_oe || ram_addr !== a || req_ready) bad = 1;
            act++;
            @(negedge clk);
            g++;
        end
        check(act == E_RD, "R2", "read strobe cycles", act, E_RD);
        check(!bad, "R6", "read strobes/ownership", bad, 0);
        check(rsp_valid === 1'b1, "R2", "rsp_valid at end", rsp_valid, 1);
        check(rsp_rdata === exp, "R2", "read data", rsp_rdata, exp);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2", "rsp_valid one cycle", rsp_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic t_write_read();
        do_write(19'h00000, 8'hA5, 0);
        do_read(19'h00000, 8'hA5);           // R10 read follows write
        do_write(19'h7FFFF, 8'hFF, 0);
        do_write(19'h12345, 8'h00, 0);
        do_read(19'h7FFFF, 8'hFF);
        do_read(19'h12345, 8'h00);
    endtask

    task automatic t_unwritten();
        do_read(19'h0ABCD, 8'hEE);
    endtask

    task automatic t_busy_ignored();
        do_write(19'h00100, 8'h3C, 1);       // R8 poke to 0x00101 mid-access
        do_read(19'h00101, 8'hEE);
        do_read(19'h00100, 8'h3C);
    endtask

    task automatic t_read_then_write();
        do_read(19'h00100, 8'h3C);
        do_write(19'h00100, 8'hC3, 0);       // R10 write follows read, R7 turn-around
        do_read(19'h00100, 8'hC3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_write_read();
        t_unwritten();
        t_busy_ignored();
        t_read_then_write();
        repeat (2) @(negedge clk);
        check_idle("R1");
        done = 1;
        finish_run();
    end
endmodule